// File: doc/BRIEF.md
# Month Length Decoder

This block tells a calendar display how many days the current month has. It takes a month number and a flag that marks a leap year. From these it drives four mutually exclusive lines, one for each possible month length: 28, 29, 30 and 31 days. It also gives the same answer as a small binary number.

The block is purely combinational and has no clock. The outputs follow the inputs after the propagation delay of the gates. A month code that names no month turns every length line off, zeroes the count and raises a flag that marks the code as invalid. The surrounding watch logic can then blank or correct the display. Computing the leap flag from a year is left to the caller.

Top module: `month_len_dec`

## Requirements
- R1: `mon_i` is an unsigned binary month number, where 1 is January and 12 is December. For each code 1 to 12, exactly one of the four length lines is high.
- R2: For month 2, `len29_o` is high when `leap_i` is 1, and `len28_o` is high when `leap_i` is 0.
- R3: Months 4, 6, 9 and 11 raise `len30_o` only.
- R4: Months 1, 3, 5, 7, 8, 10 and 12 raise `len31_o` only.
- R5: For month codes 0, 13, 14 and 15, all four length lines are low and `days_o` is 0.
- R6: `days_o` equals 28, 29, 30 or 31 in binary, matching whichever length line is high. It is 0 when no length line is high.
- R7: `bad_mon_o` is high exactly when `mon_i` is outside 1 to 12.
- R8: `leap_i` has no effect on any output for any month code other than 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mon_i | input | 4 | Month number in binary, 1 to 12 valid |
| leap_i | input | 1 | High in a leap year |
| len28_o | output | 1 | Month has 28 days |
| len29_o | output | 1 | Month has 29 days |
| len30_o | output | 1 | Month has 30 days |
| len31_o | output | 1 | Month has 31 days |
| days_o | output | 5 | Day count in binary, 0 for an invalid month |
| bad_mon_o | output | 1 | Month code outside 1 to 12 |

## Verification
The one-hot length lines and the binary day count are produced together from the same inputs. A fault in either one can hide if only one of them is observed. The bench settles every one of the 32 combinations of month and leap flag and samples all outputs at once. Each sample is judged against a model taken from the requirements, and the count is cross-checked against the active line. The invalid flag and the zeroed outputs also arise in the same settle window for codes 0 and 13 to 15, so those codes are checked for both results together.

// File: rtl/month_len_dec.sv
module month_len_dec #(
  parameter int MON_W  = 4,
  parameter int DAYS_W = 5
) (
  input  logic [MON_W-1:0]  mon_i,
  input  logic              leap_i,
  output logic              len28_o,
  output logic              len29_o,
  output logic              len30_o,
  output logic              len31_o,
  output logic [DAYS_W-1:0] days_o,
  output logic              bad_mon_o
);

  localparam logic [MON_W-1:0] FIRST_MON = MON_W'(1);
  localparam logic [MON_W-1:0] LAST_MON  = MON_W'(12);

  logic [3:0] len_q;

  always_comb begin
    len_q = 4'b0000;
    unique case (mon_i)
      MON_W'(2):                               len_q = leap_i ? 4'b0010 : 4'b0001;
      MON_W'(4), MON_W'(6), MON_W'(9), MON_W'(11): len_q = 4'b0100;
      MON_W'(1), MON_W'(3), MON_W'(5), MON_W'(7),
      MON_W'(8), MON_W'(10), MON_W'(12):       len_q = 4'b1000;
      default:                                 len_q = 4'b0000;
    endcase
  end

  assign len28_o = len_q[0];
  assign len29_o = len_q[1];
  assign len30_o = len_q[2];
  assign len31_o = len_q[3];

  assign days_o = (|len_q) ? (DAYS_W'(28) | {{(DAYS_W-2){1'b0}}, len_q[3] | len_q[2], len_q[3] | len_q[1]})
                           : '0;

  assign bad_mon_o = (mon_i < FIRST_MON) || (mon_i > LAST_MON);

endmodule

// File: rtl/month_len_chk.sv
module month_len_chk (
  input logic [3:0] mon_i,
  input logic       leap_i,
  input logic       len28_o,
  input logic       len29_o,
  input logic       len30_o,
  input logic       len31_o,
  input logic [4:0] days_o,
  input logic       bad_mon_o
);

  logic [3:0] lines;
  assign lines = {len31_o, len30_o, len29_o, len28_o};

  always_comb begin
    assert_onehot_valid_R1: assert (bad_mon_o || $countones(lines) == 1)
      else $error("valid month without exactly one length line");
    assert_feb_leap_R2: assert (mon_i != 4'd2 || (len29_o == leap_i && len28_o == !leap_i))
      else $error("february line disagrees with leap flag");
    assert_invalid_quiet_R5: assert (!bad_mon_o || (lines == 4'b0000 && days_o == 5'd0))
      else $error("invalid month drives a length");
    assert_count_match_R6: assert ($onehot0(lines) &&
                                   (!len28_o || days_o == 5'd28) && (!len29_o || days_o == 5'd29) &&
                                   (!len30_o || days_o == 5'd30) && (!len31_o || days_o == 5'd31))
      else $error("day count disagrees with length line");
    assert_bad_flag_R7: assert (bad_mon_o == (mon_i == 4'd0 || mon_i > 4'd12))
      else $error("invalid flag wrong");
  end

endmodule

bind month_len_dec month_len_chk u_chk (
  .mon_i(mon_i), .leap_i(leap_i),
  .len28_o(len28_o), .len29_o(len29_o), .len30_o(len30_o), .len31_o(len31_o),
  .days_o(days_o), .bad_mon_o(bad_mon_o)
);

// File: tb/sim_month_len_dec.sv
module sim_month_len_dec;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [3:0] mon;
  logic       leap;
  logic       l28, l29, l30, l31, bad;
  logic [4:0] days;

  int n_chk = 0;
  int n_bad = 0;
  int cycles = 0;

  month_len_dec u0 (
    .mon_i(mon), .leap_i(leap),
    .len28_o(l28), .len29_o(l29), .len30_o(l30), .len31_o(l31),
    .days_o(days), .bad_mon_o(bad)
  );

  function automatic logic [4:0] exp_days(input logic [3:0] m, input logic lp);
    if (m == 4'd2) return lp ? 5'd29 : 5'd28;
    if (m == 4'd4 || m == 4'd6 || m == 4'd9 || m == 4'd11) return 5'd30;
    if (m >= 4'd1 && m <= 4'd12) return 5'd31;
    return 5'd0;
  endfunction

  task automatic chk(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d (mon=%0d leap=%0d)", tag, got, exp, mon, leap);
    end
  endtask

  task automatic apply(input logic [3:0] m, input logic lp);
    @(negedge clk);
    mon = m;
    leap = lp;
    #1;
  endtask

  task automatic check_all(input string tag);
    logic [4:0] e;
    e = exp_days(mon, leap);
    chk({tag, " days"}, days, e);
    chk({tag, " lines"}, {l31, l30, l29, l28},
        {e == 5'd31, e == 5'd30, e == 5'd29, e == 5'd28});
    chk({tag, " bad R7"}, bad, (e == 5'd0));
  endtask

  task automatic t_start;
    apply(4'd0, 1'b0);
    chk("R5 start lines", {l31, l30, l29, l28}, 0);
    chk("R5 start days", days, 0);
    chk("R7 start bad", bad, 1);
  endtask

  task automatic t_february;
    apply(4'd2, 1'b0);
    chk("R2 feb common", {l29, l28}, 2'b01);
    chk("R2 feb common days", days, 28);
    apply(4'd2, 1'b1);
    chk("R2 feb leap", {l29, l28}, 2'b10);
    chk("R2 feb leap days", days, 29);
  endtask

  task automatic t_thirty;
    logic [3:0] ms [4] = '{4'd4, 4'd6, 4'd9, 4'd11};
    for (int i = 0; i < 4; i++) begin
      apply(ms[i], 1'b1);
      chk("R3 thirty lines", {l31, l30, l29, l28}, 4'b0100);
      chk("R3 thirty days", days, 30);
    end
  endtask

  task automatic t_thirtyone;
    logic [3:0] ms [7] = '{4'd1, 4'd3, 4'd5, 4'd7, 4'd8, 4'd10, 4'd12};
    for (int i = 0; i < 7; i++) begin
      apply(ms[i], 1'b0);
      chk("R4 long lines", {l31, l30, l29, l28}, 4'b1000);
      chk("R4 long days", days, 31);
    end
  endtask

  task automatic t_invalid;
    logic [3:0] ms [4] = '{4'd0, 4'd13, 4'd14, 4'd15};
    for (int i = 0; i < 4; i++) begin
      for (int lp = 0; lp < 2; lp++) begin
        apply(ms[i], lp[0]);
        chk("R5 invalid lines", {l31, l30, l29, l28}, 0);
        chk("R5 invalid days", days, 0);
        chk("R7 invalid flag", bad, 1);
      end
    end
  endtask

  task automatic t_leap_ignored;
    logic [4:0] d0;
    logic [3:0] ln0;
    logic       b0;
    for (int m = 0; m < 16; m++) begin
      if (m == 2) continue;
      apply(m[3:0], 1'b0);
      d0 = days; ln0 = {l31, l30, l29, l28}; b0 = bad;
      apply(m[3:0], 1'b1);
      chk("R8 leap no effect", {days, l31, l30, l29, l28, bad}, {d0, ln0, b0});
    end
  endtask

  task automatic t_sweep;
    for (int m = 0; m < 16; m++) begin
      for (int lp = 0; lp < 2; lp++) begin
        apply(m[3:0], lp[0]);
        check_all("R1 R6 sweep");
        chk("R1 onehot count", $countones({l31, l30, l29, l28}), (m >= 1 && m <= 12) ? 1 : 0);
        chk("R6 days vs line", days,
            l28 ? 28 : l29 ? 29 : l30 ? 30 : l31 ? 31 : 0);
      end
    end
  endtask

  initial begin
    mon = 4'd0;
    leap = 1'b0;
    t_start();
    t_february();
    t_thirty();
    t_thirtyone();
    t_invalid();
    t_leap_ignored();
    t_sweep();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule